// File: doc/BRIEF.md
# Quad DAC Command Decoder and Register Bank

This block sits behind a serial receiver and interprets each finished 16-bit command word for a four-channel, 12-bit digital-to-analog converter. Every channel keeps two registers. A staging register receives new codes, and a live register drives the converter. With two registers per channel, new values can be staged on several channels and then made live together in one command, or written and made live in a single step.

Besides code updates, one reserved command form carries a power-down request. It can target one channel or all four, and it picks one of four output-termination codes. The block reports the code and an active flag for each channel. The analog side reads these to switch the output stage, and that analog side is not part of this block.

A command is accepted on any clock cycle in which `cmd_valid` is high. All outputs come from registers and show the effect of a command from the clock edge that accepts it.

Top module: `quad_dac_cmd_bank`

## Requirements
- R1: After reset, every staging and live code is 0, every channel is active (`chan_active` bit 1), and every power-down code is 2'b00.
- R2: The command word layout is: bits [15:14] load field, bits [13:12] channel select (00 = channel 0, 01 = 1, 10 = 2, 11 = 3), bits [11:0] data. Channel n sits in `dac_code[12n+11:12n]`, `pd_code[2n+1:2n]` and `chan_active[n]`.
- R3: Load 00 writes the data into the selected channel's staging register only. No live code changes.
- R4: Load 01 copies the selected channel's staging register into its live register. The data bits of the command are ignored.
- R5: Load 10 writes the data into both the staging and the live register of the selected channel.
- R6: Load 11 with select 00 writes the data into all four staging registers.
- R7: Load 11 with select 01 copies each channel's own staging register into its live register.
- R8: Load 11 with select 10 writes the data into both registers of all four channels.
- R9: Load 11 with select 11 is a power-down command. If data bit 11 is 0, data bits 10:9 name a single channel and data bits 8:7 become that channel's power-down code. The code meanings are 00 open, 01 low-ohm to ground, 10 high-ohm to ground, 11 open. That channel goes inactive, the other channels are untouched, and data bits 6:0 have no effect.
- R10: In a power-down command with data bit 11 set to 1, the code in data bits 8:7 applies to all four channels and data bits 10:9 are ignored.
- R11: A power-down command changes no staging or live code.
- R12: A powered-down channel stays inactive, and keeps its code, until a command updates its live register. That command makes it active again with code 00. A staging-only write does not wake it.
- R13: When `cmd_valid` is low, no output changes, whatever `cmd_word` holds.
- R14: `chan_active[n]` is 0 exactly while channel n is powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_word | input | 16 | Command word |
| dac_code | output | 48 | Live code of each channel, 12 bits per channel |
| pd_code | output | 8 | Power-down termination code, 2 bits per channel |
| chan_active | output | 4 | Per-channel active flag |

## Verification
The assertions assume that `cmd_valid` and `cmd_word` are driven to known values once reset is released. They also assume that a command is a single-cycle pulse, which the receiver produces, so that each accepted word has exactly one effect. The stimulus meets both assumptions. It changes inputs only on the falling clock edge, holds `cmd_valid` high for exactly one cycle per command, and sets the word to a deliberately loud pattern whenever the strobe is low. In that way, R13 is exercised against data that would otherwise cause a visible change.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    typedef enum logic [1:0] {
        LD_STAGE = 2'b00,
        LD_XFER  = 2'b01,
        LD_BOTH  = 2'b10,
        LD_WIDE  = 2'b11
    } load_e;

    typedef struct packed {
        logic       wr_stage;
        logic       wr_live;
        logic       live_from_stage;
        logic       pd_set;
        logic [1:0] pd_mode;
    } chan_ctl_t;

endpackage

// File: rtl/qdac_cmd_decode.sv
module qdac_cmd_decode #(
    parameter int NCH = 4,
    parameter int DW  = 12,
    localparam int SW = $clog2(NCH),
    localparam int WW = DW + SW + 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           valid,
    input  logic [WW-1:0]                  word,
    output qdac_pkg::chan_ctl_t [NCH-1:0]  ctl
);
    import qdac_pkg::*;

    load_e          ld;
    logic [SW-1:0]  sel;
    logic [DW-1:0]  data;
    logic           pd_all;
    logic [SW-1:0]  pd_chan;
    logic [1:0]     pd_mode;
    logic [NCH-1:0] stage_vec;

    assign ld      = load_e'(word[WW-1:WW-2]);
    assign sel     = word[DW+SW-1:DW];
    assign data    = word[DW-1:0];
    assign pd_all  = data[DW-1];
    assign pd_chan = data[DW-2 -: SW];
    assign pd_mode = data[DW-2-SW -: 2];

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        logic hit;
        assign hit = (sel == SW'(i));
        always_comb begin
            ctl[i] = '0;
            if (valid) begin
                unique case (ld)
                    LD_STAGE: ctl[i].wr_stage = hit;
                    LD_XFER: begin
                        ctl[i].wr_live         = hit;
                        ctl[i].live_from_stage = 1'b1;
                    end
                    LD_BOTH: begin
                        ctl[i].wr_stage = hit;
                        ctl[i].wr_live  = hit;
                    end
                    LD_WIDE: begin
                        unique case (sel)
                            SW'(0): ctl[i].wr_stage = 1'b1;
                            SW'(1): begin
                                ctl[i].wr_live         = 1'b1;
                                ctl[i].live_from_stage = 1'b1;
                            end
                            SW'(2): begin
                                ctl[i].wr_stage = 1'b1;
                                ctl[i].wr_live  = 1'b1;
                            end
                            default: begin
                                ctl[i].pd_set  = pd_all || (pd_chan == SW'(i));
                                ctl[i].pd_mode = pd_mode;
                            end
                        endcase
                    end
                    default: ctl[i] = '0;
                endcase
            end
        end
        assign stage_vec[i] = ctl[i].wr_stage;
    end

    // R3 R6: a staging write touches one channel or all of them, never a subset
    a_r6_stage_fanout: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(stage_vec) <= 1) || ($countones(stage_vec) == NCH));

    // R13: without a strobe no channel receives any enable
    a_r13_idle_no_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (ctl == '0));

endmodule

// File: rtl/qdac_channel.sv
module qdac_channel #(
    parameter int DW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  qdac_pkg::chan_ctl_t  ctl,
    input  logic [DW-1:0]        data,
    output logic [DW-1:0]        live_o,
    output logic [1:0]           pd_mode_o,
    output logic                 active_o
);
    typedef struct packed {
        logic [DW-1:0] stage;
        logic [DW-1:0] live;
        logic          down;
        logic [1:0]    mode;
    } chan_state_t;

    chan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl.wr_stage) st_d.stage = data;
        if (ctl.wr_live) begin
            st_d.live = ctl.live_from_stage ? st_q.stage : data;
            st_d.down = 1'b0;
            st_d.mode = 2'b00;
        end
        if (ctl.pd_set) begin
            st_d.down = 1'b1;
            st_d.mode = ctl.pd_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live_o    = st_q.live;
    assign pd_mode_o = st_q.mode;
    assign active_o  = !st_q.down;

    // R4 R7: a transfer loads the staging value held before the edge
    a_r4_xfer_from_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.wr_live && ctl.live_from_stage) |=> (st_q.live == $past(st_q.stage)));

    // R5 R8: a direct live write takes the command data
    a_r5_live_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.wr_live && !ctl.live_from_stage) |=> (live_o == $past(data)));

    // R12: a live update brings the channel back up
    a_r12_wake_on_live: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.wr_live |=> (active_o && pd_mode_o == 2'b00));

    // R12: a staging-only write leaves the power state alone
    a_r12_stage_keeps_pd: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.wr_stage && !ctl.wr_live) |=> ($stable(active_o) && $stable(pd_mode_o)));

endmodule

// File: rtl/quad_dac_cmd_bank.sv
module quad_dac_cmd_bank #(
    parameter int NCH = 4,
    parameter int DW  = 12,
    localparam int SW = $clog2(NCH),
    localparam int WW = DW + SW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [WW-1:0]     cmd_word,
    output logic [NCH*DW-1:0] dac_code,
    output logic [NCH*2-1:0]  pd_code,
    output logic [NCH-1:0]    chan_active
);
    import qdac_pkg::*;

    chan_ctl_t [NCH-1:0] ctl;

    qdac_cmd_decode #(.NCH(NCH), .DW(DW)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (cmd_valid),
        .word  (cmd_word),
        .ctl   (ctl)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        qdac_channel #(.DW(DW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl       (ctl[i]),
            .data      (cmd_word[DW-1:0]),
            .live_o    (dac_code[i*DW +: DW]),
            .pd_mode_o (pd_code[i*2 +: 2]),
            .active_o  (chan_active[i])
        );
    end

    // R13: an idle cycle changes nothing at the outputs
    a_r13_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(dac_code) && $stable(pd_code) && $stable(chan_active)));

    // R11: a power-down command leaves all live codes alone
    a_r11_pd_keeps_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[WW-1 -: SW+2] == '1) |=> $stable(dac_code));

    // R10: a global power-down takes every channel down
    a_r10_all_down: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[WW-1 -: SW+2] == '1 && cmd_word[DW-1]) |=> (chan_active == '0));

    // R9: a single-channel power-down takes at most one more channel down
    a_r9_single_down: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[WW-1 -: SW+2] == '1 && !cmd_word[DW-1])
        |=> ($countones(~chan_active & $past(chan_active)) <= 1));

endmodule

// File: tb/quad_dac_cmd_bank_test.sv
`timescale 1ns/1ps
module quad_dac_cmd_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = 16'h0000;
    logic [47:0] dac_code;
    logic [7:0]  pd_code;
    logic [3:0]  chan_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    quad_dac_cmd_bank uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .dac_code(dac_code), .pd_code(pd_code), .chan_active(chan_active)
    );

    typedef struct packed {
        logic [15:0] word;
        logic [1:0]  ch;
        logic [11:0] dac;
        logic        act;
        logic [1:0]  mode;
        logic [7:0]  req;
    } vec_t;

    // expected state of channel ch after the word is accepted
    localparam vec_t VECS [12] = '{
        '{16'h0123, 2'd0, 12'h000, 1'b1, 2'd0, 8'd3},  // R3 stage ch0 only
        '{16'h4000, 2'd0, 12'h123, 1'b1, 2'd0, 8'd4},  // R4 copy ch0, data ignored
        '{16'h9ABC, 2'd1, 12'hABC, 1'b1, 2'd0, 8'd5},  // R5 both on ch1
        '{16'h2555, 2'd2, 12'h000, 1'b1, 2'd0, 8'd3},  // R3 R2 stage ch2
        '{16'hC777, 2'd3, 12'h000, 1'b1, 2'd0, 8'd6},  // R6 stage all
        '{16'hD000, 2'd0, 12'h777, 1'b1, 2'd0, 8'd7},  // R7 copy all
        '{16'hF37F, 2'd1, 12'h777, 1'b0, 2'd2, 8'd9},  // R9 R11 ch1 down, code 10
        '{16'hFE80, 2'd0, 12'h777, 1'b0, 2'd1, 8'd10}, // R10 all down, code 01
        '{16'h0111, 2'd0, 12'h777, 1'b0, 2'd1, 8'd12}, // R12 stage does not wake
        '{16'h5000, 2'd1, 12'h777, 1'b1, 2'd0, 8'd12}, // R12 copy wakes ch1
        '{16'hE222, 2'd3, 12'h222, 1'b1, 2'd0, 8'd8},  // R8 both on all
        '{16'hF780, 2'd3, 12'h222, 1'b0, 2'd3, 8'd14}  // R14 R9 ch3 down, code 11
    };

    task automatic check(input string what, input int req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        cmd_word  = w;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = 16'hA5A5;
    endtask

    task automatic check_chan(input int ch, input logic [11:0] d, input logic a, input logic [1:0] m, input int req);
        check($sformatf("ch%0d code", ch), req, 16'(dac_code[ch*12 +: 12]), 16'(d));
        check($sformatf("ch%0d active", ch), req, 16'(chan_active[ch]), 16'(a));
        check($sformatf("ch%0d pd", ch), req, 16'(pd_code[ch*2 +: 2]), 16'(m));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int c = 0; c < 4; c++) check_chan(c, 12'h000, 1'b1, 2'd0, 1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 12; i++) begin
            send(VECS[i].word);
            check_chan(int'(VECS[i].ch), VECS[i].dac, VECS[i].act, VECS[i].mode, int'(VECS[i].req));
        end

        // R8 R9: others after the last single-channel power-down
        check_chan(2, 12'h222, 1'b1, 2'd0, 9);
        check_chan(0, 12'h222, 1'b1, 2'd0, 8);

        // R13: a loud word with the strobe low changes nothing
        @(negedge clk);
        cmd_word = 16'hEFFF;
        repeat (3) @(negedge clk);
        check_chan(0, 12'h222, 1'b1, 2'd0, 13);
        check_chan(3, 12'h222, 1'b0, 2'd3, 13);

        // R11: staging untouched by power-down; copy out ch3 staging after it
        send(16'hF880);
        send(16'h7000);
        check_chan(3, 12'h222, 1'b1, 2'd0, 11);
        check_chan(1, 12'h222, 1'b0, 2'd1, 12);

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        for (int c = 0; c < 4; c++) check_chan(c, 12'h000, 1'b1, 2'd0, 1);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule